// File: doc/BRIEF.md
# Halt, Bus-Hold and Interrupt-Entry Controller

This block tracks the processor-level condition of a small CPU core. The core is running, halted after a halt instruction, or has handed its bus to another master. The core reports a halt instruction with a single-cycle strobe. An external master asks for the bus with a level request. Interrupt requests are accepted only while an internal enable flag is set. The core sets and clears that flag with strobes from its enable and disable instructions. The controller grants the bus with an acknowledge and a float enable. It signals the start of an interrupt cycle with a one-cycle pulse.

Two pieces of history are kept across a bus hold. The first is whether the hold began while the core was halted, so that the end of the hold can return to the halted condition rather than to normal execution. The second is an enabled interrupt that arrives while the bus is granted away. That interrupt is latched and serviced as soon as the hold ends.

All state changes take effect on the clock edge that samples the inputs, so every output is visible one cycle after the input that caused it. The reset is asynchronous and active low.

Top module: `hhi_ctrl`

## Requirements
- R1: While rst_n is low, cpu_state is RUN, hold_ack, bus_float, intr_start and intr_enabled are low, and any deferred interrupt is discarded.
- R2: cpu_state is encoded as RUN=0, HALT=1 and HOLD=2. The value 3 never appears.
- R3: A halt_exec strobe in RUN moves the state to HALT on the next cycle, unless hold_req or an enabled interrupt is present in the same cycle. halt_exec has no effect in HALT or HOLD.
- R4: hold_req sampled high in RUN or HALT gives HOLD on the next cycle. hold_ack and bus_float are high exactly while the state is HOLD. HOLD persists while hold_req stays high and is left on the cycle after hold_req is sampled low.
- R5: When a hold ends with no interrupt waiting, the state returns to HALT if the hold was entered from HALT, or together with a halt_exec strobe. Otherwise it returns to RUN.
- R6: In HALT, intr_req with intr_enabled high gives RUN and a start pulse. With intr_enabled low the request is ignored and the state stays HALT.
- R7: In RUN, intr_req with intr_enabled high gives a start pulse on the next cycle and keeps RUN. It wins over a halt_exec strobe in the same cycle.
- R8: An enabled intr_req that arrives during HOLD, or in the same cycle that HOLD is granted, is held pending. It starts an interrupt cycle (start pulse, state RUN) on the cycle the hold ends, even if the hold began in HALT.
- R9: intr_start is high for exactly one cycle per accepted interrupt. The same edge clears intr_enabled.
- R10: ei_cmd sets intr_enabled and di_cmd clears it, both on the next cycle. di_cmd wins over ei_cmd, and clearing on interrupt acceptance wins over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt_exec | input | 1 | One-cycle strobe: halt instruction executed |
| hold_req | input | 1 | Bus request from another master (level) |
| intr_req | input | 1 | Interrupt request (level) |
| ei_cmd | input | 1 | Strobe: set interrupt enable |
| di_cmd | input | 1 | Strobe: clear interrupt enable |
| cpu_state | output | 2 | Current state: 0 RUN, 1 HALT, 2 HOLD |
| hold_ack | output | 1 | Bus granted to the requesting master |
| bus_float | output | 1 | Put address, data and control drivers in high impedance |
| intr_start | output | 1 | One-cycle pulse: begin an interrupt cycle |
| intr_enabled | output | 1 | Current interrupt-enable flag |

## Verification
The hardest situation to reach is a hold that begins in HALT with an enabled interrupt arriving in the middle of it. In that case the pending interrupt must override the remembered return to HALT. The stimulus halts the core, enables interrupts, raises hold_req and holds it for several cycles. It pulses intr_req during the hold and then drops hold_req. A variant raises hold_req and the interrupt in the same cycle, and another raises them together with the halt strobe. A behavioural reference model compares every output on every clock.

// File: rtl/hhi_pkg.sv
package hhi_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_HOLD = 2'd2
    } hhi_state_e;

    typedef struct packed {
        hhi_state_e state;
        logic       back_to_halt;
        logic       start;
    } hhi_fsm_t;

    localparam hhi_fsm_t FSM_RESET = '{state: ST_RUN, back_to_halt: 1'b0, start: 1'b0};
endpackage

// File: rtl/hhi_ie_flag.sv
module hhi_ie_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic accept_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (accept_i)   flag_d = 1'b0;
        else if (clr_i) flag_d = 1'b0;
        else if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/hhi_defer_latch.sv
module hhi_defer_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic capture_i,
    input  logic consume_i,
    output logic pending_o
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (consume_i)      pend_d = 1'b0;
        else if (capture_i) pend_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pending_o = pend_q;
endmodule

// File: rtl/hhi_ctrl.sv
module hhi_ctrl
    import hhi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt_exec,
    input  logic               hold_req,
    input  logic               intr_req,
    input  logic               ei_cmd,
    input  logic               di_cmd,
    output logic [STATE_W-1:0] cpu_state,
    output logic               hold_ack,
    output logic               bus_float,
    output logic               intr_start,
    output logic               intr_enabled
);
    hhi_fsm_t fsm_d, fsm_q;
    logic ie_q, pend_q;
    logic int_ok, take, defer_set, defer_clr;

    hhi_ie_flag u_ie (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (ei_cmd),
        .clr_i    (di_cmd),
        .accept_i (take),
        .flag_o   (ie_q)
    );

    hhi_defer_latch u_defer (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (defer_set),
        .consume_i (defer_clr),
        .pending_o (pend_q)
    );

    assign int_ok = intr_req & ie_q;

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.start = 1'b0;
        take        = 1'b0;
        defer_set   = 1'b0;
        defer_clr   = 1'b0;
        unique case (fsm_q.state)
            ST_RUN: begin
                if (hold_req) begin
                    fsm_d.state        = ST_HOLD;
                    fsm_d.back_to_halt = halt_exec;
                    defer_set          = int_ok;
                end else if (int_ok) begin
                    take = 1'b1;
                end else if (halt_exec) begin
                    fsm_d.state = ST_HALT;
                end
            end
            ST_HALT: begin
                if (hold_req) begin
                    fsm_d.state        = ST_HOLD;
                    fsm_d.back_to_halt = 1'b1;
                    defer_set          = int_ok;
                end else if (int_ok) begin
                    fsm_d.state = ST_RUN;
                    take        = 1'b1;
                end
            end
            ST_HOLD: begin
                if (hold_req) begin
                    defer_set = int_ok;
                end else if (pend_q || int_ok) begin
                    fsm_d.state = ST_RUN;
                    take        = 1'b1;
                    defer_clr   = 1'b1;
                end else begin
                    fsm_d.state = fsm_q.back_to_halt ? ST_HALT : ST_RUN;
                end
            end
            default: fsm_d.state = ST_RUN;
        endcase
        if (take) fsm_d.start = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= FSM_RESET;
        else        fsm_q <= fsm_d;
    end

    assign cpu_state    = fsm_q.state;
    assign hold_ack     = (fsm_q.state == ST_HOLD);
    assign bus_float    = (fsm_q.state == ST_HOLD);
    assign intr_start   = fsm_q.start;
    assign intr_enabled = ie_q;
endmodule

// File: rtl/hhi_ctrl_chk.sv
module hhi_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       halt_exec,
    input logic       hold_req,
    input logic       intr_req,
    input logic [1:0] cpu_state,
    input logic       hold_ack,
    input logic       intr_start,
    input logic       intr_enabled
);
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_state != 2'd3); // R2
    AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_state == 2'd0 && halt_exec && !hold_req && !(intr_req && intr_enabled)) |=> cpu_state == 2'd1); // R3
    AST_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_ack && hold_req) |=> hold_ack); // R4
    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack && hold_req) |=> hold_ack); // R4
    AST_HOLD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack && !hold_req) |=> !hold_ack); // R4
    AST_HALT_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_state == 2'd1 && !hold_req && !intr_enabled) |=> cpu_state == 2'd1); // R6
    AST_START_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        intr_start |-> cpu_state == 2'd0); // R7
    AST_START_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        intr_start |=> !intr_start); // R9
    AST_START_CLR_IE: assert property (@(posedge clk) disable iff (!rst_n)
        intr_start |-> !intr_enabled); // R9
endmodule

bind hhi_ctrl hhi_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .halt_exec    (halt_exec),
    .hold_req     (hold_req),
    .intr_req     (intr_req),
    .cpu_state    (cpu_state),
    .hold_ack     (hold_ack),
    .intr_start   (intr_start),
    .intr_enabled (intr_enabled)
);

// File: tb/tb_hhi_ctrl.sv
module tb_hhi_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_exec = 1'b0, hold_req = 1'b0, intr_req = 1'b0, ei_cmd = 1'b0, di_cmd = 1'b0;
    logic [1:0] cpu_state;
    logic hold_ack, bus_float, intr_start, intr_enabled;

    int total = 0;
    int bad = 0;
    string tag = "R1";

    // reference model state
    int m_state = 0, m_back = 0, m_pend = 0, m_start = 0, m_ie = 0;

    always #4 clk = ~clk;

    hhi_ctrl dut (
        .clk(clk), .rst_n(rst_n), .halt_exec(halt_exec), .hold_req(hold_req),
        .intr_req(intr_req), .ei_cmd(ei_cmd), .di_cmd(di_cmd),
        .cpu_state(cpu_state), .hold_ack(hold_ack), .bus_float(bus_float),
        .intr_start(intr_start), .intr_enabled(intr_enabled)
    );

    task automatic chk(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_tick();
        int ok, ns, nb, np, nst, ni;
        ok = (intr_req && m_ie) ? 1 : 0;
        ns = m_state; nb = m_back; np = m_pend; nst = 0; ni = m_ie;
        if (!rst_n) begin
            ns = 0; nb = 0; np = 0; ni = 0;
        end else begin
            if (m_state == 2) begin
                if (hold_req) np = (ok != 0) ? 1 : np;
                else if (m_pend != 0 || ok != 0) begin ns = 0; nst = 1; np = 0; end
                else ns = (m_back != 0) ? 1 : 0;
            end else if (hold_req) begin
                ns = 2;
                nb = (m_state == 1 || halt_exec) ? 1 : 0;
                if (ok != 0) np = 1;
            end else if (ok != 0) begin
                ns = 0; nst = 1;
            end else if (m_state == 0 && halt_exec) begin
                ns = 1;
            end
            if (nst != 0)    ni = 0;
            else if (di_cmd) ni = 0;
            else if (ei_cmd) ni = 1;
        end
        m_state = ns; m_back = nb; m_pend = np; m_start = nst; m_ie = ni;
    endtask

    task automatic compare_all();
        chk("cpu_state", cpu_state, m_state);
        chk("hold_ack", hold_ack, (m_state == 2) ? 1 : 0);
        chk("bus_float", bus_float, (m_state == 2) ? 1 : 0);
        chk("intr_start", intr_start, m_start);
        chk("intr_enabled", intr_enabled, m_ie);
    endtask

    // drive at negedge, advance one clock, compare at the next negedge
    task automatic step(input logic h, input logic hr, input logic ir, input logic e, input logic d);
        halt_exec = h; hold_req = hr; intr_req = ir; ei_cmd = e; di_cmd = d;
        @(posedge clk);
        model_tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, hold_req, 0, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        tag = "R1";
        @(negedge clk); step(0, 0, 0, 0, 0);
        chk("reset cpu_state", cpu_state, 0);
        chk("reset hold_ack", hold_ack, 0);
        chk("reset intr_enabled", intr_enabled, 0);
        rst_n = 1'b1;
        idle(1);

        // R10: enable/disable strobes and priority
        tag = "R10";
        step(0, 0, 0, 1, 0); chk("ei sets", intr_enabled, 1);
        step(0, 0, 0, 1, 1); chk("di beats ei", intr_enabled, 0);

        // R3: halt from run; halt strobe ignored in halt
        tag = "R3";
        step(1, 0, 0, 0, 0); chk("halt entered", cpu_state, 1);
        step(1, 0, 0, 0, 0); chk("halt strobe in halt", cpu_state, 1);

        // R6: disabled interrupt ignored in halt, then enabled wakes it
        tag = "R6";
        step(0, 0, 1, 0, 0); step(0, 0, 1, 0, 0); chk("disabled intr", cpu_state, 1);
        step(0, 0, 1, 1, 0); chk("ei while requesting", cpu_state, 1);
        step(0, 0, 1, 0, 0); chk("wake start", intr_start, 1);
        chk("wake state", cpu_state, 0);
        tag = "R9";
        chk("ie cleared on accept", intr_enabled, 0);
        step(0, 0, 0, 0, 0); chk("pulse one cycle", intr_start, 0);

        // R4/R5: hold from run returns to run
        tag = "R4";
        step(0, 1, 0, 0, 0); chk("grant", hold_ack, 1); chk("float", bus_float, 1);
        idle(3); chk("held", cpu_state, 2);
        step(0, 0, 0, 0, 0); chk("released", hold_ack, 0);
        tag = "R5";
        chk("back to run", cpu_state, 0);
        step(1, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0); step(0, 1, 1, 0, 0);
        step(0, 0, 0, 0, 0); chk("back to halt", cpu_state, 1);
        step(0, 0, 0, 1, 0);
        step(1, 1, 0, 0, 0);
        idle(1); step(0, 0, 0, 0, 0); chk("stays halt after hold", cpu_state, 1);

        // R8: enabled interrupt during hold from halt is deferred
        tag = "R8";
        step(0, 1, 0, 0, 0); idle(2);
        step(0, 1, 1, 0, 0); chk("no start during hold", intr_start, 0);
        step(0, 1, 0, 0, 0); idle(2);
        step(0, 0, 0, 0, 0); chk("deferred start", intr_start, 1); chk("run after deferred", cpu_state, 0);
        // hold and interrupt in the same cycle
        step(0, 0, 0, 1, 0);
        step(0, 1, 1, 0, 0); chk("hold first", cpu_state, 2);
        step(0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0); chk("same-cycle deferred", intr_start, 1);
        // hold, interrupt and halt strobe together
        step(0, 0, 0, 1, 0);
        step(1, 1, 1, 0, 0); step(0, 0, 0, 0, 0);
        chk("interrupt beats return to halt", cpu_state, 0);

        // R7: enabled interrupt in run beats halt strobe
        tag = "R7";
        step(0, 0, 0, 1, 0);
        step(1, 0, 1, 0, 0); chk("start in run", intr_start, 1); chk("stays run", cpu_state, 0);
        idle(2);

        // R1: reset during hold with a pending interrupt
        tag = "R1";
        step(0, 0, 0, 1, 0);
        step(0, 1, 1, 0, 0);
        rst_n = 1'b0;
        step(0, 1, 0, 0, 0); chk("reset in hold", hold_ack, 0);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
        chk("pending discarded", intr_start, 0);

        // R2: encoding held throughout via compare_all; final idle checks
        tag = "R2";
        idle(3); chk("run encoding", cpu_state, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule